// File: doc/BRIEF.md
# Escalating Timebase-Bit Watchdog Timer

This block is a per-core watchdog whose sense of time comes from a free-running 64-bit timebase counter held inside the block. A 6-bit period value in the control register picks one bit of that counter, and every 0-to-1 transition of the picked bit is one watchdog event. A small period value picks a high counter bit and gives a long timeout. A large value picks a low bit and gives a short one.

Events that software does not service escalate in three stages. The first event sets a "next-stage armed" status flag. The second event sets an interrupt status flag, which reaches the interrupt output only when the interrupt-enable control bit is set. The third event raises a reset request that carries the 2-bit reset-kind code from the control register. Software services the watchdog by writing ones to the status flags, which clears them. The reset-kind field locks once it holds a nonzero value. Writing a period of zero then acts as a soft disable, because the watched bit becomes the top counter bit.

A preload port writes the timebase directly, so that timeouts can be placed at a known cycle.

Top module: `tbw_watchdog`

## Requirements
- R1: After reset the control register, the status register, `irq` and `rst_req` all read zero.
- R2: The period p = {ctrl[20:17], ctrl[31:30]} selects timebase bit 63-p. The timebase increments on every clock and takes `tb_load_value` on a clock where `tb_load` is high. Only a 0-to-1 change of the selected bit is an event, and its effect on status is visible after the next clock edge. A 1-to-0 change has no effect.
- R3: An event when both status flags are clear sets status bit 31 (next-stage armed) and nothing else.
- R4: An event when status bit 31 is set and bit 30 is clear sets status bit 30 (interrupt status). `irq` equals status bit 30 AND ctrl bit 27 (interrupt enable). The status bit is set whatever ctrl bit 27 holds.
- R5: An event when both status flags are set makes `rst_req` equal ctrl[29:28], if that code is nonzero. `rst_req` then holds until `rst_n` is asserted, even across status clears. If the code is 0, no reset is requested.
- R6: A write to the status register (`reg_sel`=1) clears bit 31 and/or bit 30 for each of those bits written as one. Bits written as zero leave the flags unchanged. All other status bits read zero.
- R7: If a status write with bit 31 or bit 30 set falls in the same cycle as an event, the clear is performed and the event is dropped.
- R8: ctrl[29:28] (reset kind) can be written while it holds zero. Once it is nonzero, later writes leave it unchanged until reset.
- R9: All control bits other than ctrl[29:28] read back exactly as last written (`reg_sel`=0).
- R10: A period of zero watches timebase bit 63. Changes on the low timebase bits then produce no events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tb_load | input | 1 | Loads the timebase with `tb_load_value` on this clock |
| tb_load_value | input | 64 | Preload value for the timebase |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = control, 1 = status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| irq | output | 1 | Watchdog interrupt request |
| rst_req | output | 2 | Reset request code, zero when no reset is requested |

## Verification
A software clear of the status flags and a timebase event can land on the same clock edge. The bench forces this by preloading the timebase so that the watched bit rises at a known cycle, then placing a write-one status clear on exactly that edge. The status must then read zero, which shows the event was dropped. In the same setup, a status write of all zeros on that edge must leave the first-stage flag set, which shows that only a real clear takes priority over the event.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  localparam int CTRL_W   = 32;
  localparam int PER_W    = 6;
  // split period field: low pair and high nibble
  localparam int PLO_HI   = 31;
  localparam int PLO_LO   = 30;
  localparam int PHI_HI   = 20;
  localparam int PHI_LO   = 17;
  localparam int KIND_HI  = 29;
  localparam int KIND_LO  = 28;
  localparam int IEN_BIT  = 27;
  localparam int ARM_BIT  = 31;
  localparam int INT_BIT  = 30;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} reg_sel_e;

  typedef struct packed {
    logic [PER_W-1:0] period;
    logic             int_en;
    logic [1:0]       kind;
  } ctrl_fields_t;
endpackage

// File: rtl/tbw_timebase.sv
module tbw_timebase #(
  parameter int TB_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TB_W-1:0] load_value,
  output logic [TB_W-1:0] count
);
  logic [TB_W-1:0] count_d;

  always_comb begin
    if (load) count_d = load_value;
    else      count_d = count + TB_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/tbw_bit_watch.sv
module tbw_bit_watch #(
  parameter int TB_W  = 64,
  parameter int PER_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  count,
  input  logic [PER_W-1:0] period,
  output logic             evt
);
  localparam logic [PER_W-1:0] TOP_IDX = PER_W'(TB_W - 1);

  logic [PER_W-1:0] idx;
  logic             watched;
  logic             prev_q;

  always_comb begin
    idx     = TOP_IDX - period;
    watched = count[idx];
    evt     = watched & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= watched;
  end
endmodule

// File: rtl/tbw_ctrl_reg.sv
module tbw_ctrl_reg
  import tbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output ctrl_fields_t      fields
);
  logic [CTRL_W-1:0] ctrl_d;
  logic              kind_locked;

  always_comb begin
    kind_locked = |ctrl_q[KIND_HI:KIND_LO];
    ctrl_d      = ctrl_q;
    if (wr_en) begin
      ctrl_d = wdata;
      if (kind_locked) ctrl_d[KIND_HI:KIND_LO] = ctrl_q[KIND_HI:KIND_LO];
    end
    fields.period = {ctrl_q[PHI_HI:PHI_LO], ctrl_q[PLO_HI:PLO_LO]};
    fields.int_en = ctrl_q[IEN_BIT];
    fields.kind   = ctrl_q[KIND_HI:KIND_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // R8: a nonzero reset-kind code never changes afterwards
  p_kind_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[KIND_HI:KIND_LO] != 2'b00) |=> $stable(ctrl_q[KIND_HI:KIND_LO]));
endmodule

// File: rtl/tbw_escalate.sv
module tbw_escalate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  logic       clr_en,
  input  logic [1:0] clr_mask,
  input  logic [1:0] kind,
  output logic       arm_q,
  output logic       int_q,
  output logic [1:0] req_q
);
  logic       arm_d;
  logic       int_d;
  logic [1:0] req_d;
  logic       clr_any;

  always_comb begin
    clr_any = clr_en & (|clr_mask);
    arm_d   = arm_q;
    int_d   = int_q;
    req_d   = req_q;
    if (clr_any) begin
      arm_d = arm_q & ~clr_mask[1];
      int_d = int_q & ~clr_mask[0];
    end else if (evt) begin
      if (!arm_q)      arm_d = 1'b1;
      else if (!int_q) int_d = 1'b1;
      else if (req_q == 2'b00) req_d = kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      int_q <= 1'b0;
      req_q <= 2'b00;
    end else begin
      arm_q <= arm_d;
      int_q <= int_d;
      req_q <= req_d;
    end
  end

  // R3: first event arms the next stage only
  p_first_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !clr_any && !arm_q && !int_q) |=> (arm_q && !int_q));
  // R4: second event sets interrupt status
  p_second_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !clr_any && arm_q && !int_q) |=> int_q);
  // R7: a clear of the arm flag wins over a same-cycle event
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_mask[1]) |=> !arm_q);
  // R5: a raised reset request holds until reset
  p_req_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != 2'b00) |=> $stable(req_q));
endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog
  import tbw_pkg::*;
#(
  parameter int TB_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_load,
  input  logic [TB_W-1:0]   tb_load_value,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              irq,
  output logic [1:0]        rst_req
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [TB_W-1:0]   count;
  logic              evt;
  logic [CTRL_W-1:0] ctrl_q;
  ctrl_fields_t      fields;
  logic              ctrl_wr;
  logic              stat_wr;
  logic              arm_q;
  logic              int_q;
  logic [CTRL_W-1:0] stat_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    ctrl_wr = reg_wr & (reg_sel_e'(reg_sel) == SEL_CTRL);
    stat_wr = reg_wr & (reg_sel_e'(reg_sel) == SEL_STAT);
  end

  tbw_timebase #(.TB_W(TB_W)) u_tb (
    .clk(clk), .rst_n(rst_core_n), .load(tb_load),
    .load_value(tb_load_value), .count(count)
  );

  tbw_bit_watch #(.TB_W(TB_W), .PER_W(PER_W)) u_watch (
    .clk(clk), .rst_n(rst_core_n), .count(count),
    .period(fields.period), .evt(evt)
  );

  tbw_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .wr_en(ctrl_wr),
    .wdata(reg_wdata), .ctrl_q(ctrl_q), .fields(fields)
  );

  tbw_escalate u_esc (
    .clk(clk), .rst_n(rst_core_n), .evt(evt), .clr_en(stat_wr),
    .clr_mask(reg_wdata[ARM_BIT:INT_BIT]), .kind(fields.kind),
    .arm_q(arm_q), .int_q(int_q), .req_q(rst_req)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[ARM_BIT] = arm_q;
    stat_word[INT_BIT] = int_q;
    reg_rdata          = (reg_sel_e'(reg_sel) == SEL_STAT) ? stat_word : ctrl_q;
    irq                = int_q & fields.int_en;
  end
endmodule

// File: tb/tb_tbw_watchdog.sv
module tb_tbw_watchdog;
  logic        clk;
  logic        rst_n;
  logic        tb_load;
  logic [63:0] tb_load_value;
  logic        reg_wr;
  logic        reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [1:0]  rst_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [31:0] PER60 = 32'h001E_0000; // period 60 -> bit 3
  localparam logic [31:0] IEN   = 32'h0800_0000;
  localparam logic [31:0] CLRALL = 32'hC000_0000;

  tbw_watchdog dut (
    .clk(clk), .rst_n(rst_n), .tb_load(tb_load), .tb_load_value(tb_load_value),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tb_load = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0;
    reg_wdata = '0; tb_load_value = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  // clear status and preload timebase on the same edge (E0)
  task automatic arm(input logic [63:0] v);
    tb_load = 1'b1; tb_load_value = v;
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = CLRALL;
    @(posedge clk);
    @(negedge clk);
    tb_load = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(1'b0, v); check(v == 0, "R1 ctrl", v, 0);
    rd(1'b1, v); check(v == 0, "R1 status", v, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(rst_req == 2'b00, "R1 rst_req", rst_req, 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    do_reset();
    wr(1'b0, 32'h0355_AB21);
    rd(1'b0, v); check(v == 32'h0355_AB21, "R9 readback", v, 32'h0355_AB21);
    wr(1'b0, 32'hCCAA_5500);
    rd(1'b0, v); check(v == 32'hCCAA_5500, "R9 rewrite", v, 32'hCCAA_5500);
  endtask

  task automatic t_escalate();
    logic [31:0] v;
    do_reset();
    wr(1'b0, PER60 | 32'h2000_0000);
    step(3);
    arm(64'd7);
    step(1); rd(1'b1, v); check(v == 0, "R2 no event before rise", v, 0);
    step(1); rd(1'b1, v); check(v == 32'h8000_0000, "R3 first event", v, 32'h8000_0000);
    check(irq == 1'b0, "R3 irq", irq, 0);
    step(8); rd(1'b1, v); check(v == 32'h8000_0000, "R2 falling edge ignored", v, 32'h8000_0000);
    step(8); rd(1'b1, v); check(v == 32'hC000_0000, "R4 second event", v, 32'hC000_0000);
    check(irq == 1'b0, "R4 irq gated off", irq, 0);
    wr(1'b0, PER60 | 32'h2000_0000 | IEN);
    check(irq == 1'b1, "R4 irq enabled", irq, 1);
    step(14); check(rst_req == 2'b00, "R5 before third", rst_req, 0);
    step(1);  check(rst_req == 2'b10, "R5 third event", rst_req, 2);
    wr(1'b1, CLRALL);
    rd(1'b1, v); check(v == 0, "R6 clear all", v, 0);
    check(irq == 1'b0, "R6 irq cleared", irq, 0);
    check(rst_req == 2'b10, "R5 request held", rst_req, 2);
    wr(1'b0, PER60 | 32'h1000_0000);
    rd(1'b0, v); check(v[29:28] == 2'b10, "R8 kind locked", v[29:28], 2);
    check(rst_req == 2'b10, "R5 request after rewrite", rst_req, 2);
    do_reset();
    check(rst_req == 2'b00, "R5 cleared by reset", rst_req, 0);
  endtask

  task automatic t_kind_zero();
    logic [31:0] v;
    do_reset();
    wr(1'b0, PER60);
    step(3);
    arm(64'd7);
    step(34);
    rd(1'b1, v); check(v == 32'hC000_0000, "R5 both flags", v, 32'hC000_0000);
    check(rst_req == 2'b00, "R5 kind zero no request", rst_req, 0);
    wr(1'b0, PER60 | 32'h1000_0000);
    rd(1'b0, v); check(v[29:28] == 2'b01, "R8 writable while zero", v[29:28], 1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    do_reset();
    wr(1'b0, PER60);
    step(3);
    arm(64'd7);
    step(1);
    wr(1'b1, CLRALL);
    rd(1'b1, v); check(v == 0, "R7 clear wins over event", v, 0);
    arm(64'd7);
    step(1);
    wr(1'b1, 32'h0000_0000);
    rd(1'b1, v); check(v == 32'h8000_0000, "R6 zero write no effect", v, 32'h8000_0000);
    wr(1'b1, 32'h3FFF_FFFF);
    rd(1'b1, v); check(v == 32'h8000_0000, "R6 other bits", v, 32'h8000_0000);
  endtask

  task automatic t_period0();
    logic [31:0] v;
    do_reset();
    step(2);
    arm(64'h7FFF_FFFF_FFFF_FFFF);
    step(1); rd(1'b1, v); check(v == 0, "R10 before top bit rise", v, 0);
    step(1); rd(1'b1, v); check(v == 32'h8000_0000, "R10 top bit event", v, 32'h8000_0000);
    arm(64'd7);
    step(40); rd(1'b1, v); check(v == 0, "R10 low bits ignored", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fields();
    t_escalate();
    t_kind_zero();
    t_collide();
    t_period0();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule